// File: doc/BRIEF.md
# Double-Buffered Nibble-Loaded Converter Code Register

This block is the digital front end of a 12-bit converter. A narrow data path delivers the code four bits at a time into three input registers, one for each nibble. Each input register has its own enable, so the code can be assembled over several bus cycles in any order. A separate load strobe then copies all twelve bits at once into a holding register. Only the holding register drives the converter, so the next code can be staged while the current one stays on the output.

All strobes behave as level-sensitive transparent latches. Each level is sampled on a system clock: a register follows its data on every clock edge at which its strobe is sampled high, and it keeps its value otherwise. The block also presents the held code as a signed value for bipolar (offset-binary) use. Timing monitors report a strobe that falls before its data has been stable long enough, or a strobe pulse that is too short. The setup and width limits are counted in clock cycles.

Top module: `dbuf_dac_front`

## Requirements
- R1: Enable bit `nib_en[2]` writes `din[11:8]`, the most significant nibble. `nib_en[1]` writes `din[7:4]`. `nib_en[0]` writes `din[3:0]`, the least significant nibble. In the held code, `code[11]` is the MSB.
- R2: An input register loads its data slice on a clock edge only when `cs_n` is sampled 0 and that register's enable bit is sampled 1 at that edge. Otherwise it keeps its value.
- R3: While a nibble stays open for several cycles, the register follows its data slice on every one of those edges. It keeps the last value sampled before it closed.
- R4: While `load` is 1, the holding register copies all three input registers on every edge. While `load` is 0, `code` does not change, even when the input registers are rewritten.
- R5: The `load` transfer works the same whether `cs_n` is 0 or 1.
- R6: When a nibble is written and `load` is high on the same edge, the holding register receives the value written on that edge.
- R7: A synchronous active-high `rst` clears all input registers, the holding register, the timing monitors and `timing_err` to zero.
- R8: `code_signed` is `code` with its MSB inverted, read as two's complement. Code 0x800 gives 0, 0xFFF gives +2047 and 0x000 gives -2048.
- R9: Setup check. Bits 0..2 of `timing_err` belong to nibble strobes 0..2, and bit 3 belongs to `load`. A strobe falls when it is sampled high on one edge and low on the next. On the edge where it falls, the strobe's bit pulses high for one cycle if its data was stable for fewer than SETUP_CYC consecutive samples up to and including the last high sample. For a nibble, that data is `din`. For `load`, it is the value the input registers present to the holding register.
- R10: Width check. On the same falling edge, the bit also pulses if the strobe was high for fewer than its minimum number of samples. For a nibble strobe (`cs_n` low together with its enable), the minimum is OVERLAP_CYC. For `load`, the minimum is PULSE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; gates nibble writes only |
| nib_en | input | 3 | Per-nibble write enables (2 = high, 0 = low) |
| load | input | 1 | Transfer strobe into the holding register |
| din | input | 12 | Data bus; each nibble feeds its own input register |
| code | output | 12 | Held converter code |
| code_signed | output | 12 | Offset-binary view of the code as two's complement |
| timing_err | output | 4 | One-cycle setup/width violation pulses, per strobe |

## Verification
The assertions assume that each control input carries one clean level per clock cycle. They also assume that the timing monitors see a strobe fall only after reset has been low for at least two edges. The properties on held values depend on the inputs being defined on every edge. The stimulus drives all inputs on the falling clock edge, always from known values. It keeps reset high for the first cycles and does not toggle strobes until reset has been released. Timing violations are provoked deliberately, through a one-cycle strobe and through data that changes on the last open cycle. This exercises the monitors without relying on undefined input levels.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int NIB_W_DEF   = 4;
    localparam int NIB_N_DEF   = 3;
    localparam int SETUP_DEF   = 2;
    localparam int PULSE_DEF   = 2;
    localparam int OVERLAP_DEF = 3;

    // Which strobe a monitor slot watches.
    typedef enum logic [0:0] {
        STB_NIBBLE   = 1'b0,
        STB_TRANSFER = 1'b1
    } stb_kind_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Counter width able to hold values up to maxv, plus one guard bit.
    function automatic int cnt_width(input int maxv);
        return $clog2(maxv + 1) + 1;
    endfunction

endpackage

// File: rtl/dbuf_nibble_reg.sv
module dbuf_nibble_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open_i,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_next,
    output logic [W-1:0] q
);
    // The value this register will hold after the edge; also fed forward
    // to the holding stage so a same-edge transfer sees fresh data.
    always_comb q_next = open_i ? d : q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end
endmodule

// File: rtl/dbuf_stable_count.sv
module dbuf_stable_count #(
    parameter int W     = 12,
    parameter int CNT_W = 3,
    parameter int CAP   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     val,
    output logic [CNT_W-1:0] run_now
);
    localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

    logic [W-1:0]     val_q;
    logic [CNT_W-1:0] cnt_q;

    // Consecutive samples equal to the present one, current sample included.
    always_comb begin
        if (val != val_q)       run_now = CNT_W'(1);
        else if (cnt_q >= CAP_C) run_now = CAP_C;
        else                    run_now = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            cnt_q <= '0;
        end else begin
            val_q <= val;
            cnt_q <= run_now;
        end
    end
endmodule

// File: rtl/dbuf_strobe_timer.sv
module dbuf_strobe_timer #(
    parameter int CNT_W     = 3,
    parameter int CAP       = 3,
    parameter int MIN_HIGH  = 2,
    parameter int MIN_SETUP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [CNT_W-1:0] stable_now,
    output logic             viol
);
    localparam logic [CNT_W-1:0] CAP_C   = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] HIGH_C  = CNT_W'(MIN_HIGH);
    localparam logic [CNT_W-1:0] SETUP_C = CNT_W'(MIN_SETUP);

    logic             s_q;
    logic [CNT_W-1:0] high_run;
    logic [CNT_W-1:0] last_stab;
    logic             falling;
    logic             short_pulse;
    logic             early_fall;

    always_comb begin
        falling     = s_q && !strobe;
        short_pulse = high_run < HIGH_C;
        early_fall  = last_stab < SETUP_C;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= 1'b0;
            high_run  <= '0;
            last_stab <= '0;
            viol      <= 1'b0;
        end else begin
            s_q  <= strobe;
            viol <= falling && (short_pulse || early_fall);  // R9, R10
            if (strobe) begin
                if (!s_q)                high_run <= CNT_W'(1);
                else if (high_run < CAP_C) high_run <= high_run + CNT_W'(1);
                last_stab <= stable_now;
            end
        end
    end
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
    import dbuf_pkg::*;
#(
    parameter int NIB_W       = NIB_W_DEF,
    parameter int NIB_N       = NIB_N_DEF,
    parameter int SETUP_CYC   = SETUP_DEF,
    parameter int PULSE_CYC   = PULSE_DEF,
    parameter int OVERLAP_CYC = OVERLAP_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic [NIB_N-1:0]         nib_en,
    input  logic                     load,
    input  logic [NIB_W*NIB_N-1:0]   din,
    output logic [NIB_W*NIB_N-1:0]   code,
    output logic signed [NIB_W*NIB_N-1:0] code_signed,
    output logic [NIB_N:0]           timing_err
);
    localparam int CODE_W = NIB_W * NIB_N;
    localparam int NSTB   = NIB_N + 1;
    localparam int CAP    = imax(SETUP_CYC, imax(PULSE_CYC, OVERLAP_CYC));
    localparam int CNT_W  = cnt_width(CAP);

    logic [NIB_N-1:0]  open_nib;
    logic [CODE_W-1:0] inreg_d;
    logic [CODE_W-1:0] inreg_q;
    logic [CODE_W-1:0] hold_q;
    logic [CNT_W-1:0]  din_run;
    logic [CNT_W-1:0]  reg_run;

    // First stage: one input register per nibble (R1, R2, R3).
    for (genvar g = 0; g < NIB_N; g++) begin : g_nib
        assign open_nib[g] = !cs_n && nib_en[g];
        dbuf_nibble_reg #(.W(NIB_W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .open_i (open_nib[g]),
            .d      (din[g*NIB_W +: NIB_W]),
            .q_next (inreg_d[g*NIB_W +: NIB_W]),
            .q      (inreg_q[g*NIB_W +: NIB_W])
        );
    end

    // Second stage: transfer ignores chip select and sees same-edge data
    // (R4, R5, R6).
    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (load) hold_q <= inreg_d;
    end

    always_comb begin
        code        = hold_q;
        code_signed = {~hold_q[CODE_W-1], hold_q[CODE_W-2:0]};  // R8
    end

    // Stability of the data each strobe closes on.
    dbuf_stable_count #(.W(CODE_W), .CNT_W(CNT_W), .CAP(CAP)) u_din_stab (
        .clk     (clk),
        .rst     (rst),
        .val     (din),
        .run_now (din_run)
    );

    dbuf_stable_count #(.W(CODE_W), .CNT_W(CNT_W), .CAP(CAP)) u_reg_stab (
        .clk     (clk),
        .rst     (rst),
        .val     (inreg_d),
        .run_now (reg_run)
    );

    // One monitor per strobe; the last slot watches the transfer strobe.
    for (genvar k = 0; k < NSTB; k++) begin : g_mon
        localparam stb_kind_e KIND = (k < NIB_N) ? STB_NIBBLE : STB_TRANSFER;
        if (KIND == STB_NIBBLE) begin : g_n
            dbuf_strobe_timer #(
                .CNT_W(CNT_W), .CAP(CAP),
                .MIN_HIGH(OVERLAP_CYC), .MIN_SETUP(SETUP_CYC)
            ) u_tmr (
                .clk        (clk),
                .rst        (rst),
                .strobe     (open_nib[k]),
                .stable_now (din_run),
                .viol       (timing_err[k])
            );
        end else begin : g_t
            dbuf_strobe_timer #(
                .CNT_W(CNT_W), .CAP(CAP),
                .MIN_HIGH(PULSE_CYC), .MIN_SETUP(SETUP_CYC)
            ) u_tmr (
                .clk        (clk),
                .rst        (rst),
                .strobe     (load),
                .stable_now (reg_run),
                .viol       (timing_err[k])
            );
        end
    end
endmodule

// File: rtl/dbuf_dac_chk.sv
module dbuf_dac_chk #(
    parameter int NIB_W = 4,
    parameter int NIB_N = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cs_n,
    input logic [NIB_N-1:0]         nib_en,
    input logic                     load,
    input logic [NIB_W*NIB_N-1:0]   din,
    input logic [NIB_W*NIB_N-1:0]   inreg,
    input logic [NIB_W*NIB_N-1:0]   code,
    input logic [NIB_W*NIB_N-1:0]   code_signed,
    input logic [NIB_N:0]           timing_err
);
    localparam int CW = NIB_W * NIB_N;
    localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

    for (genvar g = 0; g < NIB_N; g++) begin : g_n
        p_nib_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (cs_n || !nib_en[g]) |=> $stable(inreg[g*NIB_W +: NIB_W]));
        p_nib_write_r1: assert property (@(posedge clk) disable iff (rst)
            (!cs_n && nib_en[g]) |=> inreg[g*NIB_W +: NIB_W] == $past(din[g*NIB_W +: NIB_W]));
    end

    p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(code));

    // With select inactive the input registers cannot move, so the transfer
    // must deliver their prior contents (R5).
    p_xfer_no_cs_r5: assert property (@(posedge clk) disable iff (rst)
        (load && cs_n) |=> code == $past(inreg));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (code == '0 && inreg == '0 && timing_err == '0));

    p_mid_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (code == MID) == (code_signed == '0));

    p_err_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        timing_err[NIB_N] |-> (!$past(load) && $past(load, 2)));
endmodule

bind dbuf_dac_front dbuf_dac_chk #(.NIB_W(NIB_W), .NIB_N(NIB_N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .nib_en      (nib_en),
    .load        (load),
    .din         (din),
    .inreg       (inreg_q),
    .code        (code),
    .code_signed (code_signed),
    .timing_err  (timing_err)
);

// File: tb/tb_dbuf_dac_front.sv
`timescale 1ns/1ps
module tb_dbuf_dac_front;
    localparam int SETUP = 2, PULSE = 2, OVERLAP = 3, SAT = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic [2:0]  nib_en = '0;
    logic        load = 1'b0;
    logic [11:0] din = '0;
    logic [11:0] code;
    logic signed [11:0] code_signed;
    logic [3:0]  timing_err;

    always #2.5 clk = ~clk;

    dbuf_dac_front dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .nib_en(nib_en), .load(load),
        .din(din), .code(code), .code_signed(code_signed), .timing_err(timing_err)
    );

    typedef struct {
        logic [11:0] code;
        logic [3:0]  err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0;

    // Reference state
    logic [11:0] m_in, m_hold, m_din_q, m_reg_q;
    int          m_dcnt, m_rcnt;
    logic [3:0]  m_sq;
    int          m_run[4], m_stab[4];

    task automatic model_clear();
        m_in = '0; m_hold = '0; m_din_q = '0; m_reg_q = '0;
        m_dcnt = 0; m_rcnt = 0; m_sq = '0;
        for (int k = 0; k < 4; k++) begin m_run[k] = 0; m_stab[k] = 0; end
    endtask

    task automatic step(input logic c, input logic [2:0] e, input logic l,
                        input logic [11:0] d, input string tag);
        exp_t it;
        logic [11:0] nin;
        logic [3:0]  stb, err;
        int dnow, rnow, minw, stabv;
        @(negedge clk);
        rst = 1'b0; cs_n = c; nib_en = e; load = l; din = d;
        nin = m_in;
        for (int g = 0; g < 3; g++)
            if (!c && e[g]) nin[g*4 +: 4] = d[g*4 +: 4];
        dnow = (d == m_din_q) ? ((m_dcnt + 1 > SAT) ? SAT : m_dcnt + 1) : 1;
        rnow = (nin == m_reg_q) ? ((m_rcnt + 1 > SAT) ? SAT : m_rcnt + 1) : 1;
        stb = {l, !c && e[2], !c && e[1], !c && e[0]};
        err = '0;
        for (int k = 0; k < 4; k++) begin
            minw  = (k == 3) ? PULSE : OVERLAP;
            stabv = (k == 3) ? rnow : dnow;
            if (m_sq[k] && !stb[k])
                err[k] = (m_run[k] < minw) || (m_stab[k] < SETUP);
            if (stb[k]) begin
                m_run[k]  = m_sq[k] ? ((m_run[k] + 1 > SAT) ? SAT : m_run[k] + 1) : 1;
                m_stab[k] = stabv;
            end
        end
        m_sq = stb;
        m_din_q = d; m_dcnt = dnow; m_reg_q = nin; m_rcnt = rnow;
        m_in = nin;
        if (l) m_hold = nin;
        it.code = m_hold; it.err = err; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic do_reset(input int n);
        exp_t it;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1; cs_n = 1'b1; nib_en = '0; load = 1'b0;
            model_clear();
            it.code = '0; it.err = '0; it.tag = "R7";
            sb.push_back(it);
        end
    endtask

    task automatic wr(input logic [2:0] e, input logic [11:0] d, input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, e, 1'b0, d, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 3'b000, 1'b0, din, tag);
    endtask

    task automatic xfer(input logic c, input int n, input string tag);
        for (int i = 0; i < n; i++) step(c, 3'b000, 1'b1, din, tag);
    endtask

    // Monitor: compare one item per clock, shortly after the edge.
    always @(posedge clk) begin
        exp_t it;
        logic [11:0] es;
        #1;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            es = it.code ^ 12'h800;  // R8 mapping
            checks++;
            if (code !== it.code || timing_err !== it.err || code_signed !== es) begin
                fails++;
                $display("FAIL %s: code=%h signed=%h err=%b expected code=%h signed=%h err=%b",
                         it.tag, code, code_signed, timing_err, it.code, es, it.err);
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset(3);                                  // R7
        // R1: high nibble only reaches code[11:8]
        wr(3'b100, 12'hABC, 3, "R1"); idle(2, "R1");
        xfer(1'b1, 2, "R1"); idle(2, "R1");
        // R1: middle and low nibbles
        wr(3'b010, 12'h5D6, 3, "R1"); wr(3'b001, 12'h5D6, 3, "R1");
        idle(2, "R1"); xfer(1'b0, 2, "R1"); idle(2, "R1");
        // R2: enables with select inactive change nothing
        for (int i = 0; i < 3; i++) step(1'b1, 3'b111, 1'b0, 12'hFFF, "R2");
        idle(2, "R2"); xfer(1'b1, 2, "R2"); idle(2, "R2");
        // R3: open nibble follows every sample, keeps the last
        step(1'b0, 3'b001, 1'b0, 12'h001, "R3");
        step(1'b0, 3'b001, 1'b0, 12'h007, "R3");
        step(1'b0, 3'b001, 1'b0, 12'h00E, "R3");
        step(1'b0, 3'b001, 1'b0, 12'h00E, "R3");
        idle(2, "R3"); xfer(1'b1, 2, "R3"); idle(2, "R3");
        // R4: rewrite input registers, code must not move
        wr(3'b111, 12'h123, 3, "R4"); idle(3, "R4");
        // R5: transfer with select inactive
        xfer(1'b1, 2, "R5"); idle(2, "R5");
        // R6: write and transfer on the same edges
        for (int i = 0; i < 3; i++) step(1'b0, 3'b111, 1'b1, 12'h9A4, "R6");
        idle(2, "R6");
        // R8: mid-scale, top and bottom codes
        wr(3'b111, 12'h800, 3, "R8"); idle(2, "R8"); xfer(1'b1, 2, "R8"); idle(2, "R8");
        wr(3'b111, 12'hFFF, 3, "R8"); idle(2, "R8"); xfer(1'b1, 2, "R8"); idle(2, "R8");
        wr(3'b111, 12'h000, 3, "R8"); idle(2, "R8"); xfer(1'b1, 2, "R8"); idle(2, "R8");
        // R9: data changes on the last open sample of a nibble strobe
        step(1'b0, 3'b010, 1'b0, 12'h030, "R9");
        step(1'b0, 3'b010, 1'b0, 12'h030, "R9");
        step(1'b0, 3'b010, 1'b0, 12'h070, "R9");
        idle(3, "R9");
        // R9: transfer right after the input value changes
        wr(3'b100, 12'h600, 3, "R9"); xfer(1'b1, 2, "R9"); idle(2, "R9");
        // R10: one-sample nibble strobe, one-sample transfer
        wr(3'b001, 12'h0C2, 3, "R10"); idle(1, "R10");
        step(1'b0, 3'b001, 1'b0, 12'h0C2, "R10"); idle(3, "R10");
        xfer(1'b1, 1, "R10"); idle(3, "R10");
        // R7: reset after activity
        do_reset(2); idle(2, "R7");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule